// File: doc/BRIEF.md
# 16-bit xoroshiro plus-plus pseudorandom word generator

This block is a small pseudorandom source for on-chip use. It keeps 32 bits of state as two 16-bit halves. On every clock where the step strobe is high, it registers one 16-bit output word and moves the state one step forward. The state update uses only XOR, fixed shifts and fixed rotations. The output scrambler adds a 16-bit rotate-and-add on top of that. There is no multiplier anywhere, so the whole generator fits in a few dozen LUTs.

The reset constants are fixed, so the output sequence after every reset is always the same and is known in advance. The output register clears to zero on reset. The first generated word therefore shows up one clock after the first enabled cycle. Callers that want a fresh word pulse the strobe and read the output on the following cycle. Callers that want a stream hold the strobe high.

Top module: `xo16pp_gen`

## Requirements
- R1: While reset is applied, and after it is released until the first enabled clock edge, `rnd_o` reads 0x0000.
- R2: Starting from reset, the first eight words that appear on `rnd_o` are 0x0201, 0x6269, 0xae16, 0x12a2, 0x4ae8, 0xd719, 0x0c52 and 0x984b, in that order.
- R3: The ninth to sixteenth words are 0x1df1, 0x743c, 0xdba0, 0xbcc6, 0x34c9, 0x746c, 0x3643 and 0x07ff, in that order.
- R4: While `step_en` is low, `rnd_o` and the internal state hold their values. When `step_en` goes high again, the sequence resumes with the next word, and no word is skipped.
- R5: Pulling `rst_n` low in the middle of a run clears `rnd_o` to 0x0000 straight away. After reset is released, the sequence starts again from 0x0201.
- R6: A word produced at an enabled clock edge is visible on `rnd_o` right after that edge. Each enabled edge changes the internal state.
- R7: The state halves load lo=0x0001 and hi=0x0000 at reset. Each enabled edge registers the output rotl16(lo+hi, 9)+lo and then moves the state to t=lo^hi, lo'=rotl16(lo,13)^t^(t<<5), hi'=rotl16(t,10). All sums are taken modulo 2^16. The 32-bit state is never all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset. It is asserted asynchronously and released synchronously inside the block. |
| step_en | input | 1 | Step strobe. When high, the next word is registered and the state advances. |
| rnd_o | output | 16 | Registered pseudorandom word |

## Verification
The hardest case to reach is a long idle gap in the middle of the sequence, followed by a resume. A fault that lets the state creep forward, or that drops one word at the enable edge, shows up only as a single shifted value. To reach this case, the bench steps exactly three words from reset, parks the strobe low for several cycles and then expects the fourth published word. A second case pulls reset low in the middle of a stream and checks both that the output clears at once and that the sequence restarts cleanly. A 1000-word run then compares every output against a model built from the update equations. This catches faults that only show up after the first sixteen published words.

// File: rtl/xo16pp_pkg.sv
package xo16pp_pkg;
  localparam int unsigned XO_W       = 16;
  localparam int unsigned XO_ROT_A   = 13;
  localparam int unsigned XO_SHL_B   = 5;
  localparam int unsigned XO_ROT_C   = 10;
  localparam int unsigned XO_ROT_D   = 9;
  localparam logic [XO_W-1:0] XO_SEED_LO = 16'h0001;
  localparam logic [XO_W-1:0] XO_SEED_HI = 16'h0000;
endpackage

// File: rtl/xo16pp_rst_sync.sv
module xo16pp_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/xo16pp_rotl.sv
module xo16pp_rotl #(
  parameter int unsigned W = 16,
  parameter int unsigned K = 1
) (
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  localparam int unsigned KM = K % W;
  logic [2*W-1:0] dbl;

  always_comb begin
    dbl  = {din, din} << KM;
    dout = dbl[2*W-1:W];
  end
endmodule

// File: rtl/xo16pp_state.sv
module xo16pp_state
  import xo16pp_pkg::*;
#(
  parameter int unsigned W       = XO_W,
  parameter int unsigned ROT_A   = XO_ROT_A,
  parameter int unsigned SHL_B   = XO_SHL_B,
  parameter int unsigned ROT_C   = XO_ROT_C,
  parameter logic [W-1:0] SEED_LO = XO_SEED_LO,
  parameter logic [W-1:0] SEED_HI = XO_SEED_HI
) (
  input  logic         clk,
  input  logic         srst_n,
  input  logic         adv,
  output logic [W-1:0] s_lo,
  output logic [W-1:0] s_hi
);
  logic [W-1:0] mix_t;
  logic [W-1:0] lo_rot;
  logic [W-1:0] t_rot;
  logic [W-1:0] lo_d;
  logic [W-1:0] hi_d;

  xo16pp_rotl #(.W(W), .K(ROT_A)) u_rot_lo (.din(s_lo),  .dout(lo_rot));
  xo16pp_rotl #(.W(W), .K(ROT_C)) u_rot_t  (.din(mix_t), .dout(t_rot));

  always_comb begin
    mix_t = s_hi ^ s_lo;
    lo_d  = s_lo;
    hi_d  = s_hi;
    if (adv) begin
      lo_d = lo_rot ^ mix_t ^ (mix_t << SHL_B);
      hi_d = t_rot;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      s_lo <= SEED_LO;
      s_hi <= SEED_HI;
    end else begin
      s_lo <= lo_d;
      s_hi <= hi_d;
    end
  end
endmodule

// File: rtl/xo16pp_scramble.sv
module xo16pp_scramble
  import xo16pp_pkg::*;
#(
  parameter int unsigned W     = XO_W,
  parameter int unsigned ROT_D = XO_ROT_D
) (
  input  logic [W-1:0] s_lo,
  input  logic [W-1:0] s_hi,
  output logic [W-1:0] word
);
  logic [W-1:0] sum_w;
  logic [W-1:0] sum_rot;

  xo16pp_rotl #(.W(W), .K(ROT_D)) u_rot_sum (.din(sum_w), .dout(sum_rot));

  always_comb begin
    sum_w = s_lo + s_hi;
    word  = sum_rot + s_lo;
  end
endmodule

// File: rtl/xo16pp_gen.sv
module xo16pp_gen
  import xo16pp_pkg::*;
#(
  parameter int unsigned W       = XO_W,
  parameter int unsigned ROT_A   = XO_ROT_A,
  parameter int unsigned SHL_B   = XO_SHL_B,
  parameter int unsigned ROT_C   = XO_ROT_C,
  parameter int unsigned ROT_D   = XO_ROT_D,
  parameter logic [W-1:0] SEED_LO = XO_SEED_LO,
  parameter logic [W-1:0] SEED_HI = XO_SEED_HI
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step_en,
  output logic [W-1:0] rnd_o
);
  logic         srst_n;
  logic [W-1:0] s_lo;
  logic [W-1:0] s_hi;
  logic [W-1:0] scr_w;
  logic [W-1:0] out_d;

  xo16pp_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  xo16pp_state #(
    .W(W), .ROT_A(ROT_A), .SHL_B(SHL_B), .ROT_C(ROT_C),
    .SEED_LO(SEED_LO), .SEED_HI(SEED_HI)
  ) u_state (
    .clk    (clk),
    .srst_n (srst_n),
    .adv    (step_en),
    .s_lo   (s_lo),
    .s_hi   (s_hi)
  );

  xo16pp_scramble #(.W(W), .ROT_D(ROT_D)) u_scr (
    .s_lo (s_lo),
    .s_hi (s_hi),
    .word (scr_w)
  );

  always_comb begin
    out_d = rnd_o;
    if (step_en) begin
      out_d = scr_w;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      rnd_o <= '0;
    end else begin
      rnd_o <= out_d;
    end
  end
endmodule

// File: rtl/xo16pp_chk.sv
module xo16pp_chk #(
  parameter int unsigned W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         srst_n,
  input logic         step_en,
  input logic [W-1:0] rnd_o,
  input logic [W-1:0] s_lo,
  input logic [W-1:0] s_hi
);
  p_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !srst_n |=> rnd_o == '0);

  p_hold_out_r4: assert property (@(posedge clk) disable iff (!srst_n)
    !step_en |=> $stable(rnd_o));

  p_hold_state_r4: assert property (@(posedge clk) disable iff (!srst_n)
    !step_en |=> ($stable(s_lo) && $stable(s_hi)));

  p_step_moves_r6: assert property (@(posedge clk) disable iff (!srst_n)
    step_en |=> ({s_lo, s_hi} != $past({s_lo, s_hi})));

  p_nonzero_r7: assert property (@(posedge clk) disable iff (!srst_n)
    {s_lo, s_hi} != '0);
endmodule

bind xo16pp_gen xo16pp_chk #(.W(W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .srst_n  (srst_n),
  .step_en (step_en),
  .rnd_o   (rnd_o),
  .s_lo    (s_lo),
  .s_hi    (s_hi)
);

// File: tb/xo16pp_gen_bench.sv
`timescale 1ns/1ps
module xo16pp_gen_bench;
  logic        clk;
  logic        rst_n;
  logic        step_en;
  logic [15:0] rnd_o;

  int n_chk;
  int n_bad;

  logic [15:0] ref_w [16];

  xo16pp_gen u_xo16pp_gen (
    .clk     (clk),
    .rst_n   (rst_n),
    .step_en (step_en),
    .rnd_o   (rnd_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [15:0] rotl(input logic [15:0] x, input int k);
    return (x << k) | (x >> (16 - k));
  endfunction

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic do_reset();
    step_en = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // R1 and R6: zero until the first enabled edge, word right after it
  task automatic t_reset_state();
    do_reset();
    check("R1 after release", rnd_o, 16'h0000);
    repeat (3) @(negedge clk);
    check("R1 idle", rnd_o, 16'h0000);
    step_en = 1'b1;
    @(negedge clk);
    step_en = 1'b0;
    check("R6 one-edge latency", rnd_o, 16'h0201);
    @(negedge clk);
    check("R6 single pulse", rnd_o, 16'h0201);
  endtask

  // R2 and R3: the sixteen published words in a continuous stream
  task automatic t_sequence();
    do_reset();
    step_en = 1'b1;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      check(i < 8 ? "R2 word" : "R3 word", rnd_o, ref_w[i]);
    end
    step_en = 1'b0;
  endtask

  // R4: idle gap after three words, then resume
  task automatic t_hold();
    do_reset();
    step_en = 1'b1;
    repeat (3) @(negedge clk);
    step_en = 1'b0;
    check("R4 before gap", rnd_o, 16'hae16);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check("R4 held", rnd_o, 16'hae16);
    end
    step_en = 1'b1;
    @(negedge clk);
    check("R4 resume", rnd_o, 16'h12a2);
    @(negedge clk);
    step_en = 1'b0;
    check("R4 resume next", rnd_o, 16'h4ae8);
  endtask

  // R5: reset in the middle of a stream
  task automatic t_restart();
    do_reset();
    step_en = 1'b1;
    repeat (6) @(negedge clk);
    check("R5 mid-run", rnd_o, 16'hd719);
    rst_n = 1'b0;
    #1;
    check("R5 async clear", rnd_o, 16'h0000);
    @(negedge clk);
    step_en = 1'b0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R5 cleared", rnd_o, 16'h0000);
    step_en = 1'b1;
    @(negedge clk);
    check("R5 restart word1", rnd_o, 16'h0201);
    @(negedge clk);
    step_en = 1'b0;
    check("R5 restart word2", rnd_o, 16'h6269);
  endtask

  // R7: 1000 words against a model of the stated equations, with gaps
  task automatic t_model();
    logic [15:0] lo, hi, t, exp;
    int bad_before;
    do_reset();
    lo = 16'h0001;
    hi = 16'h0000;
    bad_before = n_bad;
    for (int i = 0; i < 1000; i++) begin
      exp = rotl(lo + hi, 9) + lo;
      t   = lo ^ hi;
      lo  = rotl(lo, 13) ^ t ^ (t << 5);
      hi  = rotl(t, 10);
      step_en = 1'b1;
      @(negedge clk);
      if (i % 7 == 3) begin
        step_en = 1'b0;
        @(negedge clk);
      end
      check("R7 model", rnd_o, exp);
      if (n_bad - bad_before > 5) break;
    end
    step_en = 1'b0;
  endtask

  initial begin
    ref_w = '{16'h0201, 16'h6269, 16'hae16, 16'h12a2, 16'h4ae8, 16'hd719,
              16'h0c52, 16'h984b, 16'h1df1, 16'h743c, 16'hdba0, 16'hbcc6,
              16'h34c9, 16'h746c, 16'h3643, 16'h07ff};
  end

  initial begin
    n_chk   = 0;
    n_bad   = 0;
    rst_n   = 1'b0;
    step_en = 1'b0;
    fork
      begin
        t_reset_state();
        t_sequence();
        t_hold();
        t_restart();
        t_model();
      end
      begin
        repeat (50000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule